// File: doc/BRIEF.md
# Montgomery Ladder Scalar-Multiplication Sequencer

This block is the top-level controller for a scalar multiplication Q = k·P on an elliptic curve over a binary field. The curve points are held in projective coordinates. It does no field arithmetic. It latches the scalar when a start request arrives, then sends a fixed stream of point commands to an external arithmetic controller over a command/done handshake. That controller owns two working point registers, called the first register and the second register. It carries out each command and pulses a done strobe when the command is complete.

The stream always begins with one initialisation command, which loads the first register with P and the second register with 2P. After that, the sequencer walks the scalar from bit KEY_W-2 down to bit 0. The top bit is taken to be 1. For every bit it issues exactly one point addition and then exactly one point doubling. The bit value only chooses which register receives each result, so the order and timing of commands are the same for every key. Once the last doubling completes, the sequencer pulses a ready flag, and the product is left in the first register.

Top module: `mlad_ladder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `cmd_valid_o`, `busy_o` and `ready_o` are all 0.
- R2: A `start_i` pulse seen while idle captures `scalar_i`. From the next cycle on, `busy_o` is 1 and the first command is presented with `cmd_op_o` = 2'b00 (initialise: first register ← P, second register ← 2P).
- R3: Once presented, a command keeps `cmd_valid_o` high and `cmd_op_o` and `cmd_dst_o` unchanged until `cmd_done_i` is sampled high. The next command appears in the following cycle.
- R4: After the initialise command, each scalar bit from KEY_W-2 down to 0 produces an addition (`cmd_op_o` = 2'b01) followed by a doubling (`cmd_op_o` = 2'b10). A full run therefore has 2·(KEY_W-1)+1 commands.
- R5: `cmd_dst_o` = 0 names the first register and 1 names the second. For an addition (first register + second register), `cmd_dst_o` is the inverse of the current bit. For a doubling, `cmd_dst_o` equals the current bit, and that register is doubled in place.
- R6: When the run ends with a scalar whose top bit is 1, the first register holds k·P and the second register holds (k+1)·P.
- R7: `ready_o` is high for exactly one cycle, the cycle after the final doubling is acknowledged. `busy_o` falls in that same cycle.
- R8: While busy, `start_i` and `scalar_i` are ignored. The running multiplication finishes with its original scalar and its original command count.
- R9: With a responder of fixed latency L cycles per command, `busy_o` stays high for exactly L·(2·(KEY_W-1)+1) cycles, whatever the key.
- R10: `cmd_done_i` is ignored while no command is presented: it starts nothing and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only while idle |
| scalar_i | input | KEY_W | Scalar k, captured with an accepted start |
| cmd_valid_o | output | 1 | A command is being presented |
| cmd_op_o | output | 2 | Command: 00 initialise, 01 add, 10 double |
| cmd_dst_o | output | 1 | Target point register: 0 first, 1 second |
| cmd_done_i | input | 1 | Completion strobe from the arithmetic controller |
| busy_o | output | 1 | Multiplication in progress |
| ready_o | output | 1 | One-cycle pulse when the product is in the first register |

## Verification
The bench builds the block with KEY_W = 16, so each run has 31 commands and the whole ladder is short enough to repeat for many keys. The responder's latency changes per vector, from 1 cycle (commands back to back, no gap between them) up to 5 cycles. This tests the hold behaviour and also checks that run length depends only on latency and not on the key. The responder follows each command with integer multiples of P standing in for points. Because of this, the final register contents show directly whether the steering was correct, for keys with the top bit only, all ones, and alternating bit patterns.

// File: rtl/mlad_pkg.sv
package mlad_pkg;

  typedef enum logic [1:0] {
    OP_INIT = 2'b00,
    OP_ADD  = 2'b01,
    OP_DBL  = 2'b10
  } mlad_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INIT,
    ST_ADD,
    ST_DBL
  } mlad_st_e;

  // Register that receives the sum for the given scalar bit.
  function automatic logic add_target(input logic b);
    return ~b;
  endfunction

  // Register that is doubled in place for the given scalar bit.
  function automatic logic dbl_target(input logic b);
    return b;
  endfunction

  // First bit index visited; the top bit is implied to be 1.
  function automatic int first_idx(input int width);
    return width - 2;
  endfunction

endpackage

// File: rtl/mlad_keyreg.sv
module mlad_keyreg #(
  parameter int KEY_W = 16,
  localparam int IDX_W = (KEY_W > 2) ? $clog2(KEY_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [KEY_W-1:0] scalar_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [KEY_W-1:0] key_o,
  output logic             bit_o
);

  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q <= '0;
    end else if (load_i) begin
      key_q <= scalar_i;
    end
  end

  assign key_o = key_q;
  assign bit_o = key_q[idx_i];

endmodule

// File: rtl/mlad_bitctr.sv
module mlad_bitctr
  import mlad_pkg::*;
#(
  parameter int KEY_W = 16,
  localparam int IDX_W = (KEY_W > 2) ? $clog2(KEY_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);

  localparam logic [IDX_W-1:0] IDX_START = IDX_W'(first_idx(KEY_W));

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (load_i) begin
      idx_q <= IDX_START;
    end else if (step_i && (idx_q != '0)) begin
      idx_q <= idx_q - 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == '0);

endmodule

// File: rtl/mlad_fsm.sv
module mlad_fsm
  import mlad_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     done_i,
  input  logic     last_i,
  input  logic     bit_i,
  output logic     load_o,
  output logic     step_o,
  output logic     cmd_valid_o,
  output mlad_op_e op_o,
  output logic     dst_o,
  output logic     busy_o,
  output logic     ready_o
);

  mlad_st_e state_q, state_d;
  logic     ready_q;
  logic     accept_w;
  logic     finish_w;

  assign cmd_valid_o = (state_q != ST_IDLE);
  assign accept_w    = cmd_valid_o && done_i;
  assign finish_w    = (state_q == ST_DBL) && accept_w && last_i;
  assign load_o      = (state_q == ST_IDLE) && start_i;
  assign step_o      = (state_q == ST_DBL) && accept_w;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i)  state_d = ST_INIT;
      ST_INIT: if (accept_w) state_d = ST_ADD;
      ST_ADD:  if (accept_w) state_d = ST_DBL;
      ST_DBL:  if (accept_w) state_d = last_i ? ST_IDLE : ST_ADD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    op_o  = OP_INIT;
    dst_o = 1'b0;
    case (state_q)
      ST_ADD: begin
        op_o  = OP_ADD;
        dst_o = add_target(bit_i);
      end
      ST_DBL: begin
        op_o  = OP_DBL;
        dst_o = dbl_target(bit_i);
      end
      default: begin
        op_o  = OP_INIT;
        dst_o = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= finish_w;
    end
  end

  assign busy_o  = cmd_valid_o;
  assign ready_o = ready_q;

endmodule

// File: rtl/mlad_ladder.sv
module mlad_ladder
  import mlad_pkg::*;
#(
  parameter int KEY_W = 16,
  localparam int IDX_W = (KEY_W > 2) ? $clog2(KEY_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [KEY_W-1:0] scalar_i,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_op_o,
  output logic             cmd_dst_o,
  input  logic             cmd_done_i,
  output logic             busy_o,
  output logic             ready_o
);

  logic             load_w;
  logic             step_w;
  logic             last_w;
  logic             bit_w;
  logic [IDX_W-1:0] idx_w;
  logic [KEY_W-1:0] key_w;
  mlad_op_e         op_w;

  mlad_keyreg #(.KEY_W(KEY_W)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_w),
    .scalar_i (scalar_i),
    .idx_i    (idx_w),
    .key_o    (key_w),
    .bit_o    (bit_w)
  );

  mlad_bitctr #(.KEY_W(KEY_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_w),
    .step_i (step_w),
    .idx_o  (idx_w),
    .last_o (last_w)
  );

  mlad_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .done_i      (cmd_done_i),
    .last_i      (last_w),
    .bit_i       (bit_w),
    .load_o      (load_w),
    .step_o      (step_w),
    .cmd_valid_o (cmd_valid_o),
    .op_o        (op_w),
    .dst_o       (cmd_dst_o),
    .busy_o      (busy_o),
    .ready_o     (ready_o)
  );

  assign cmd_op_o = op_w;

endmodule

// File: rtl/mlad_checker.sv
module mlad_checker #(
  parameter int KEY_W = 16,
  localparam int IDX_W = (KEY_W > 2) ? $clog2(KEY_W) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             cmd_valid_o,
  input logic [1:0]       cmd_op_o,
  input logic             cmd_dst_o,
  input logic             cmd_done_i,
  input logic             busy_o,
  input logic             ready_o,
  input logic [KEY_W-1:0] key_w,
  input logic [IDX_W-1:0] idx_w
);

  p_first_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid_o) |-> (cmd_op_o == 2'b00));

  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_done_i) |=>
      (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_dst_o)));

  p_add_then_dbl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_done_i && cmd_op_o == 2'b01) |=>
      (cmd_valid_o && cmd_op_o == 2'b10));

  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_done_i && cmd_op_o == 2'b10 && idx_w != '0) |=>
      (idx_w == IDX_W'($past(idx_w) - 1'b1)));

  p_add_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_op_o == 2'b01) |-> (cmd_dst_o == ~key_w[idx_w]));

  p_dbl_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_op_o == 2'b10) |-> (cmd_dst_o == key_w[idx_w]));

  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  p_ready_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (!busy_o &&
      $past(cmd_valid_o && cmd_done_i && cmd_op_o == 2'b10 && idx_w == '0)));

  p_key_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_o) |-> $stable(key_w));

  p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> !busy_o);

endmodule

bind mlad_ladder mlad_checker #(.KEY_W(KEY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_op_o    (cmd_op_o),
  .cmd_dst_o   (cmd_dst_o),
  .cmd_done_i  (cmd_done_i),
  .busy_o      (busy_o),
  .ready_o     (ready_o),
  .key_w       (key_w),
  .idx_w       (idx_w)
);

// File: tb/sim_mlad_ladder.sv
`timescale 1ns/1ps
module sim_mlad_ladder;

  localparam int KEY_W = 16;
  localparam int NCMD  = 2 * (KEY_W - 1) + 1;

  // {scalar[15:0], latency[3:0]}
  localparam logic [19:0] VEC [0:5] = '{
    {16'h8000, 4'd1},
    {16'hFFFF, 4'd3},
    {16'hA5A5, 4'd2},
    {16'h8001, 4'd5},
    {16'hC35A, 4'd1},
    {16'h9249, 4'd4}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [KEY_W-1:0] scalar_i = '0;
  logic             cmd_valid_o;
  logic [1:0]       cmd_op_o;
  logic             cmd_dst_o;
  logic             cmd_done_i;
  logic             busy_o;
  logic             ready_o;
  logic             resp_done = 1'b0;
  logic             stray_done = 1'b0;

  assign cmd_done_i = resp_done | stray_done;

  always #2 clk = ~clk;

  mlad_ladder #(.KEY_W(KEY_W)) u0 (
    .clk, .rst_n, .start_i, .scalar_i, .cmd_valid_o, .cmd_op_o,
    .cmd_dst_o, .cmd_done_i, .busy_o, .ready_o
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Responder model state: points as integer multiples of P.
  int               lat = 1;
  int               cnt = 0;
  int               ncmd = 0;
  int               seq_err = 0;
  int               hold_err = 0;
  int               busy_cyc = 0;
  int               ready_cnt = 0;
  int               pt [2];
  logic [KEY_W-1:0] cur_key = '0;
  logic [1:0]       seen_op = '0;
  logic             seen_dst = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (busy_o)  busy_cyc++;
    if (ready_o) ready_cnt++;
    if (!cmd_valid_o) begin
      resp_done = 1'b0;
      cnt = 0;
    end else begin
      if (cnt == 0) begin
        seen_op  = cmd_op_o;
        seen_dst = cmd_dst_o;
      end else if (cmd_op_o != seen_op || cmd_dst_o != seen_dst) begin
        hold_err++;
      end
      if (cnt == lat - 1) begin
        resp_done = 1'b1;
        cnt = 0;
        if (ncmd == 0) begin
          if (cmd_op_o != 2'b00) seq_err++;
          pt[0] = 1;
          pt[1] = 2;
        end else begin
          int  b;
          logic kb;
          b  = KEY_W - 2 - (ncmd - 1) / 2;
          kb = (b >= 0) ? cur_key[b] : 1'b0;
          if (ncmd % 2 == 1) begin
            if (cmd_op_o != 2'b01 || cmd_dst_o != !kb) seq_err++;
            pt[cmd_dst_o] = pt[0] + pt[1];
          end else begin
            if (cmd_op_o != 2'b10 || cmd_dst_o != kb) seq_err++;
            pt[cmd_dst_o] = 2 * pt[cmd_dst_o];
          end
        end
        ncmd++;
      end else begin
        resp_done = 1'b0;
        cnt++;
      end
    end
  end

  task automatic run_one(input logic [KEY_W-1:0] key, input int l, input bit poke);
    int guard;
    @(posedge clk); #1;
    lat = l; ncmd = 0; seq_err = 0; hold_err = 0;
    busy_cyc = 0; ready_cnt = 0; pt[0] = 0; pt[1] = 0;
    cur_key = key;
    start_i = 1'b1; scalar_i = key;
    @(posedge clk); #1;
    start_i = 1'b0; scalar_i = ~key;
    check(busy_o && cmd_valid_o && cmd_op_o == 2'b00, "R2", "first command init",
          {busy_o, cmd_valid_o, cmd_op_o}, 4'b1100);
    if (poke) begin
      repeat (7) @(posedge clk);
      #1 start_i = 1'b1; scalar_i = 16'h8003;
      @(posedge clk); #1 start_i = 1'b0;
    end
    guard = 0;
    while (!ready_o && guard < 2000) begin
      @(posedge clk); #1;
      guard++;
    end
    check(!busy_o, "R7", "busy low with ready", busy_o, 0);
    repeat (3) @(posedge clk);
    #1;
    check(ncmd == NCMD, "R4", "command count", ncmd, NCMD);
    check(seq_err == 0, "R5", "order/steering errors", seq_err, 0);
    check(hold_err == 0, "R3", "command changed before done", hold_err, 0);
    check(pt[0] == int'(key), "R6", "first register multiple", pt[0], key);
    check(pt[1] == int'(key) + 1, "R6", "second register multiple", pt[1], key + 1);
    check(ready_cnt == 1, "R7", "ready pulse width", ready_cnt, 1);
    check(busy_cyc == NCMD * l, "R9", "busy cycles", busy_cyc, NCMD * l);
    if (poke) check(pt[0] == int'(key), "R8", "restart ignored while busy", pt[0], key);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!cmd_valid_o && !busy_o && !ready_o, "R1", "outputs in reset",
          {cmd_valid_o, busy_o, ready_o}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(!cmd_valid_o && !busy_o && !ready_o, "R1", "outputs after reset",
          {cmd_valid_o, busy_o, ready_o}, 0);

    for (int i = 0; i < 6; i++) begin
      run_one(VEC[i][19:4], int'(VEC[i][3:0]), 1'b0);
    end

    // R10: stray done while idle
    stray_done = 1'b1;
    @(posedge clk); #1;
    stray_done = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(!cmd_valid_o && !busy_o && !ready_o, "R10", "stray done in idle",
          {cmd_valid_o, busy_o, ready_o}, 0);
    run_one(16'hB00B, 2, 1'b0);

    // R8: start and scalar changes while busy
    run_one(16'hE71D, 3, 1'b1);
    run_one(16'h8000, 1, 1'b1);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule